// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

A slave can be cut off in the middle of a byte, for example by a host reset. It then keeps holding SDA low, and no further transfer can begin. This block sits between the main I2C controller and the open-drain pad enables. It runs whenever a soft reset of the controller is requested. For the whole run it keeps the controller in reset and takes over both pad enables. It releases SDA and checks whether the bus is idle, which means SCL and SDA both read high. If the bus is not idle, it clocks SCL until the slave lets go or an attempt limit is reached.

Each attempt first checks whether the bus has become free. If it has not, the attempt drives SCL low for about ten microseconds and then releases it for the same time. That interval is a cycle count taken from the clock frequency parameter. The run ends as soon as a check finds the bus free, so a slave that needs three clocks gets three. If the bus is already idle at the start, the block finishes in a handful of cycles and produces no clock at all. When the block is idle, the controller's own enables pass straight through to the pads.

Top module: `i2c_bus_unjam`

## Requirements
- R1: While idle, `pad_scl_oe` and `pad_sda_oe` follow `ctl_scl_oe` and `ctl_sda_oe`, and `ctrl_rst` and `done` are low; after reset `ok` and `fail` are low.
- R2: A `start` sampled high while idle raises `ctrl_rst` on the next cycle. `ctrl_rst` stays high through the cycle in which `done` is high and is low on the cycle after it.
- R3: While `ctrl_rst` is high, `pad_sda_oe` is 0, meaning SDA is released. `pad_scl_oe` is 1, meaning SCL is pulled low, only during a recovery pulse.
- R4: The bus counts as free only when `scl_in` and `sda_in` are both 1, each sampled through a two-flop synchroniser. If the bus is free at the start, `done` rises within 8 cycles of `start` with no SCL pulse and `ok` set.
- R5: Each recovery pulse holds `pad_scl_oe` high for exactly CLK_MHZ*LOW_US cycles. SCL is then released for the same number of cycles before the free check is repeated.
- R6: Before each pulse the free condition is checked again. The run ends with `ok` as soon as the check passes, so a slave that releases SDA after N clocks, with N no greater than MAX_TRIES, receives exactly N pulses.
- R7: At most MAX_TRIES pulses are issued. If the bus is still not free after the last one, the run ends with `fail`=1 and `ok`=0, and SCL and SDA are released.
- R8: `done` is high for exactly one cycle per run. At that point exactly one of `ok` and `fail` is 1, and both hold their value until the next accepted `start`.
- R9: A `start` that arrives while a run is in progress is ignored: neither the pulse count nor the number of `done` pulses changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Soft-reset request that starts a recovery run |
| ctl_scl_oe | input | 1 | SCL pull-low enable from the main controller |
| ctl_sda_oe | input | 1 | SDA pull-low enable from the main controller |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| pad_scl_oe | output | 1 | SCL pull-low enable to the pad |
| pad_sda_oe | output | 1 | SDA pull-low enable to the pad |
| ctrl_rst | output | 1 | Holds the main controller in reset |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Last run ended with the bus free |
| fail | output | 1 | Last run exhausted its attempts |

## Verification
The bench models a slave that holds SDA low until it has seen a chosen number of SCL rising edges. The run is repeated with that number at 0, 1, 3, exactly the attempt limit, one above the limit and far above it. Zero separates the fast path from the pulsing path. The small counts show that the sequence stops at the first free check. The two counts on either side of the limit separate a last-pulse success from a failure. A further case holds SCL low from outside while SDA is free, which shows that a free SDA alone never counts as an idle bus. Directed cases cover pass-through while idle, the width of each low phase, and a second `start` arriving in the middle of a run.

// File: rtl/i2c_bus_unjam.sv
`timescale 1ns/1ps
module i2c_bus_unjam #(
  parameter int CLK_MHZ   = 200,
  parameter int LOW_US    = 10,
  parameter int MAX_TRIES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ctl_scl_oe,
  input  logic ctl_sda_oe,
  input  logic scl_in,
  input  logic sda_in,
  output logic pad_scl_oe,
  output logic pad_sda_oe,
  output logic ctrl_rst,
  output logic done,
  output logic ok,
  output logic fail
);
  localparam int LOW_CYC = CLK_MHZ * LOW_US;
  localparam int CW = $clog2(LOW_CYC + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {IDLE, SETTLE, CHECK, LOW, HIGH, FINISH} st_t;

  st_t           state;
  logic [1:0]    scl_s, sda_s;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;

  wire bus_free = scl_s[1] & sda_s[1];
  wire cnt_end  = (cnt == CW'(LOW_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      tries <= '0;
      ok    <= 1'b0;
      fail  <= 1'b0;
    end else begin
      case (state)
        IDLE: if (start) begin
          state <= SETTLE;
          cnt   <= '0;
          tries <= '0;
          ok    <= 1'b0;
          fail  <= 1'b0;
        end
        SETTLE: begin
          if (cnt == CW'(2)) begin
            state <= CHECK;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        CHECK: begin
          if (bus_free) begin
            ok    <= 1'b1;
            state <= FINISH;
          end else if (tries == TW'(MAX_TRIES)) begin
            fail  <= 1'b1;
            state <= FINISH;
          end else begin
            state <= LOW;
            cnt   <= '0;
          end
        end
        LOW: begin
          if (cnt_end) begin
            state <= HIGH;
            cnt   <= '0;
            tries <= tries + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        HIGH: begin
          if (cnt_end) begin
            state <= CHECK;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign ctrl_rst   = (state != IDLE);
  assign pad_scl_oe = (state == IDLE) ? ctl_scl_oe : (state == LOW);
  assign pad_sda_oe = (state == IDLE) & ctl_sda_oe;
  assign done       = (state == FINISH);
endmodule

// File: rtl/i2c_bus_unjam_chk.sv
`timescale 1ns/1ps
module i2c_bus_unjam_chk #(
  parameter int MAX_TRIES = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ctl_scl_oe,
  input logic pad_scl_oe,
  input logic pad_sda_oe,
  input logic ctrl_rst,
  input logic done,
  input logic ok,
  input logic fail
);
  int pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulses <= 0;
    else if (!ctrl_rst) pulses <= 0;
    else if (pad_scl_oe && !$past(pad_scl_oe)) pulses <= pulses + 1;
  end

  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rst |-> pad_scl_oe == ctl_scl_oe);

  // R2
  rst_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst) |-> $past(start));

  // R2
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ctrl_rst);

  // R3
  sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |-> !pad_sda_oe);

  // R7
  try_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= MAX_TRIES);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ fail));
endmodule

bind i2c_bus_unjam i2c_bus_unjam_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ctl_scl_oe(ctl_scl_oe),
  .pad_scl_oe(pad_scl_oe), .pad_sda_oe(pad_sda_oe), .ctrl_rst(ctrl_rst),
  .done(done), .ok(ok), .fail(fail));

// File: tb/i2c_bus_unjam_bench.sv
`timescale 1ns/1ps
module i2c_bus_unjam_bench;
  localparam int MHZ = 200, LUS = 1, MAXT = 6;
  localparam int LOWC = MHZ * LUS;
  localparam int NV = 7;
  // {stuck clocks, scl held low, expected pulses, expected ok}
  localparam int VT [NV][4] = '{
    '{0, 0, 0, 1}, '{1, 0, 1, 1}, '{3, 0, 3, 1}, '{MAXT, 0, MAXT, 1},
    '{MAXT + 1, 0, MAXT, 0}, '{20, 0, MAXT, 0}, '{0, 1, MAXT, 0}};

  logic clk = 0, rst_n = 0, start = 0, ctl_scl_oe = 0, ctl_sda_oe = 0;
  logic scl_hold = 0;
  logic pad_scl_oe, pad_sda_oe, ctrl_rst, done, ok, fail;
  int scl_rises = 0, base = 0, target = 0;
  int oe_rises = 0, done_cnt = 0, bad_w = 0, sda_bad = 0, cur_w = 0;
  int tests = 0, fails = 0, last_lat = 0;
  logic prev_oe = 0;

  wire scl_line = !pad_scl_oe && !scl_hold;
  wire sda_line = !pad_sda_oe && ((scl_rises - base) >= target);

  always #2.5 clk = ~clk;

  i2c_bus_unjam #(.CLK_MHZ(MHZ), .LOW_US(LUS), .MAX_TRIES(MAXT)) u_i2c_bus_unjam (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl_scl_oe(ctl_scl_oe),
    .ctl_sda_oe(ctl_sda_oe), .scl_in(scl_line), .sda_in(sda_line),
    .pad_scl_oe(pad_scl_oe), .pad_sda_oe(pad_sda_oe), .ctrl_rst(ctrl_rst),
    .done(done), .ok(ok), .fail(fail));

  always @(posedge scl_line) scl_rises <= scl_rises + 1;

  always @(negedge clk) begin
    if (ctrl_rst && pad_scl_oe && !prev_oe) oe_rises <= oe_rises + 1;
    if (ctrl_rst && pad_scl_oe) cur_w <= cur_w + 1;
    else begin
      if (prev_oe && ctrl_rst && cur_w != LOWC) bad_w <= bad_w + 1;
      cur_w <= 0;
    end
    if (ctrl_rst && pad_sda_oe) sda_bad <= sda_bad + 1;
    if (done) done_cnt <= done_cnt + 1;
    prev_oe <= pad_scl_oe;
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int tgt, input bit hold, input int exp_p, input bit exp_ok,
                     input bit again);
    int p0, d0, w0, s0, n;
    bit seen;
    @(negedge clk);
    base = scl_rises; target = tgt; scl_hold = hold;
    p0 = oe_rises; d0 = done_cnt; w0 = bad_w; s0 = sda_bad;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(ctrl_rst == 1, "R2 rst on start", ctrl_rst, 1);
    seen = 0; n = 1;
    for (int i = 0; i < 5000 && !seen; i++) begin
      if (again && i == 50) start = 1;
      if (again && i == 51) start = 0;
      if (done) begin
        seen = 1;
        last_lat = n;
        chk(ctrl_rst == 1, "R2 rst held at done", ctrl_rst, 1);
      end else begin
        @(negedge clk);
        n++;
      end
    end
    start = 0;
    chk(seen, "R8 done seen", seen, 1);
    @(negedge clk);
    chk(done == 0, "R8 done one cycle", done, 0);
    chk(ctrl_rst == 0, "R2 rst released", ctrl_rst, 0);
    chk(oe_rises - p0 == exp_p, "R6/R7 pulse count", oe_rises - p0, exp_p);
    chk(ok == exp_ok && fail == !exp_ok, "R7/R8 result", {ok, fail}, {exp_ok, !exp_ok});
    chk(bad_w == w0, "R5 low width", bad_w - w0, 0);
    chk(sda_bad == s0, "R3 sda released", sda_bad - s0, 0);
    repeat (5) @(negedge clk);
    chk(done_cnt - d0 == 1, "R8/R9 one done", done_cnt - d0, 1);
    chk(ok == exp_ok, "R8 ok held", ok, exp_ok);
    scl_hold = 0;
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ctrl_rst && !done && !ok && !fail, "R1 reset state",
        {ctrl_rst, done, ok, fail}, 0);
    rst_n = 1;
    @(negedge clk);
    ctl_scl_oe = 1; ctl_sda_oe = 0;
    #1;
    chk(pad_scl_oe == 1 && pad_sda_oe == 0, "R1 pass scl", {pad_scl_oe, pad_sda_oe}, 2);
    ctl_scl_oe = 0; ctl_sda_oe = 1;
    #1;
    chk(pad_scl_oe == 0 && pad_sda_oe == 1, "R1 pass sda", {pad_scl_oe, pad_sda_oe}, 1);
    ctl_sda_oe = 0;

    for (int v = 0; v < NV; v++)
      run(VT[v][0], VT[v][1] != 0, VT[v][2], VT[v][3] != 0, 0);

    run(0, 0, 0, 1, 0);
    chk(last_lat <= 8, "R4 fast free finish", last_lat, 8);

    run(3, 0, 3, 1, 1);   // R9 second start mid-run

    ctl_scl_oe = 1; ctl_sda_oe = 1;
    #1;
    chk(pad_scl_oe && pad_sda_oe && !ctrl_rst, "R1 pass after run",
        {pad_scl_oe, pad_sda_oe, ctrl_rst}, 6);
    ctl_scl_oe = 0; ctl_sda_oe = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule